// File: doc/BRIEF.md
# Phase-Aligned Four-Channel Clock Divider Bank

The block divides one input clock in four independent channels. Each channel has its own divide ratio, its own phase offset, a start polarity and a flag that opts it out of alignment. Each channel drives a group of three outputs, and all three always carry the same divided waveform. Every output is a registered level that advances once per input clock cycle.

A resynchronization request freezes every participating channel at its start level. The request comes either from an asynchronous active-low pin or from a software bit. When the request is withdrawn, all participating channels restart together. Each channel first waits for its phase offset and then produces its waveform, so the relative phase between channels is repeatable. Channels flagged to opt out keep running untouched.

All settings are written into a staged copy through a simple write port. An update strobe moves them into the active copy, so the active settings change in a single cycle.

Top module: `clkdiv_sync_bank`

## Requirements
- R1: While reset is held and after its release, every channel runs at ratio 2 with offset 0, start level high, no opt-out and no request pending. After reset the outputs alternate high and low every cycle, starting high.
- R2: A write stores its data in the staged copy only. Outputs follow the active copy, and the active copy is loaded from the staged copy when `upd` is high. A write in the same cycle as `upd` is included in that update. Channel addresses are 0 to 3, with data bits [5:0] for the ratio, [10:6] for the offset, [11] for the start level and [12] for opt-out. Address 4 bit [0] is the software request. Writes to addresses 5 to 7 are discarded.
- R3: If `sync_n` is sampled low at clock edge k, every participating channel shows its start level from edge k+PIPE_LAT+2 on (edge k+14 with the default depth). The level stays static as long as the request lasts.
- R4: Once the request ends, a channel keeps its start level for its offset reduced modulo its ratio. It then begins a period at cycle 0 of its waveform. Channels with equal ratios therefore differ in phase by exactly their offset difference.
- R5: A channel with the opt-out bit set is never frozen and is not realigned by a request.
- R6: The software request acts only through the active copy. When the active bit changes at edge U, outputs respond from edge U+PIPE_LAT+1. The pin and the software bit are ORed, so the request lasts while either one asks for it.
- R7: The effective ratio is the ratio field limited to the range 2 to 32. Each period spends ceil(ratio/2) cycles at the start level and floor(ratio/2) cycles at the opposite level.
- R8: The three outputs of channel c (bits 3c to 3c+2 of `clk_out`) are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Asynchronous active-low resynchronization request |
| wr_en | input | 1 | Write strobe for the staged settings |
| wr_addr | input | 3 | Staged register address |
| wr_data | input | 13 | Write data |
| upd | input | 1 | Copies the staged settings into the active set |
| clk_out | output | 12 | Three outputs per channel, channel 0 in the low bits |

## Verification
Two pairs of functions can act in the same cycle, and the bench provokes both. In the first, a write and the update strobe are issued together. In the second, the pin request and the software request overlap, so that one is withdrawn while the other still holds the channels. A scoreboard model predicts every output bit in every cycle. It derives the freeze window from its own history of pin samples and active software bits. The per-cycle compare then shows whether the simultaneous write reached the active set, and whether the channels stayed frozen until the last request ended.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int RATIO_W = 6;
  localparam int OFF_W   = 5;
  localparam int CFG_W   = RATIO_W + OFF_W + 2;
  localparam int RATIO_MIN = 2;
  localparam int RATIO_MAX = 32;

  typedef struct packed {
    logic               ign;
    logic               sh;
    logic [OFF_W-1:0]   off;
    logic [RATIO_W-1:0] ratio;
  } ch_cfg_t;

  localparam ch_cfg_t CFG_RST = '{ign: 1'b0, sh: 1'b1, off: '0,
                                  ratio: RATIO_W'(RATIO_MIN)};

  // Limit the programmed ratio to the legal range.
  function automatic logic [RATIO_W-1:0] eff_ratio(input logic [RATIO_W-1:0] f);
    if (f < RATIO_W'(RATIO_MIN))      return RATIO_W'(RATIO_MIN);
    else if (f > RATIO_W'(RATIO_MAX)) return RATIO_W'(RATIO_MAX);
    else                              return f;
  endfunction

  // Offset reduced modulo the effective ratio (ratio never below 2).
  function automatic logic [OFF_W-1:0] off_wrap(input logic [OFF_W-1:0] o,
                                                input logic [RATIO_W-1:0] r);
    return OFF_W'(RATIO_W'({1'b0, o}) % r);
  endfunction

  // Cycles per period spent at the start level.
  function automatic logic [RATIO_W-1:0] first_half(input logic [RATIO_W-1:0] r);
    return (r + RATIO_W'(1)) >> 1;
  endfunction

endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CFG_W-1:0]       wr_data,
  input  logic                   upd,
  output ch_cfg_t [NCH-1:0]      act,
  output logic                   soft_act
);

  localparam logic [ADDR_W-1:0] SOFT_ADDR = ADDR_W'(NCH);

  ch_cfg_t [NCH-1:0] stg;
  ch_cfg_t [NCH-1:0] stg_nxt;
  logic              soft_stg;
  logic              soft_nxt;

  // Staged value after this cycle's write; the update copies it.
  for (genvar c = 0; c < NCH; c++) begin : g_wr
    assign stg_nxt[c] = (wr_en && wr_addr == ADDR_W'(c)) ? ch_cfg_t'(wr_data) : stg[c];
  end
  assign soft_nxt = (wr_en && wr_addr == SOFT_ADDR) ? wr_data[0] : soft_stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg      <= {NCH{CFG_RST}};
      act      <= {NCH{CFG_RST}};
      soft_stg <= 1'b0;
      soft_act <= 1'b0;
    end else begin
      stg      <= stg_nxt;
      soft_stg <= soft_nxt;
      if (upd) begin
        act      <= stg_nxt;
        soft_act <= soft_nxt;
      end
    end
  end

  // R2: active settings move only on an update strobe
  p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(act) && $stable(soft_act)));

endmodule

// File: rtl/cdiv_sync_pipe.sv
module cdiv_sync_pipe #(
  parameter int PIPE_LAT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic soft_req,
  output logic hold
);

  localparam int SC_W = $clog2(PIPE_LAT + 1);

  logic                s1_n, s2_n;
  logic                req_in;
  logic [PIPE_LAT-1:0] dl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_n <= 1'b1;
      s2_n <= 1'b1;
    end else begin
      s1_n <= sync_n;
      s2_n <= s1_n;
    end
  end

  assign req_in = ~s2_n | soft_req;

  if (PIPE_LAT == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dl <= '0;
      else        dl <= req_in;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dl <= '0;
      else        dl <= {dl[PIPE_LAT-2:0], req_in};
    end
  end

  assign hold = dl[PIPE_LAT-1];

  // Checker state: how long the request has stayed at its present value.
  logic            req_last;
  logic [SC_W-1:0] stable_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_last   <= 1'b0;
      stable_cnt <= '0;
    end else begin
      req_last <= req_in;
      if (req_in != req_last)                    stable_cnt <= '0;
      else if (stable_cnt != SC_W'(PIPE_LAT))    stable_cnt <= stable_cnt + SC_W'(1);
    end
  end

  // R3 / R6: a request level that persisted through the whole pipe is what hold shows
  p_pipe_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_cnt >= SC_W'(PIPE_LAT - 1)) |-> (hold == req_last));

endmodule

// File: rtl/cdiv_chan.sv
module cdiv_chan
  import cdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sync_hold,
  input  ch_cfg_t cfg,
  output logic    lvl
);

  logic [RATIO_W-1:0] ratio_e;
  logic [RATIO_W-1:0] half;
  logic [RATIO_W-1:0] cnt;
  logic [OFF_W-1:0]   wt;
  logic               hold;
  logic               running;
  logic               wrap;

  assign ratio_e = eff_ratio(cfg.ratio);
  assign half    = first_half(ratio_e);
  assign hold    = sync_hold & ~cfg.ign;
  assign running = ~hold && (wt == '0);
  assign wrap    = cnt >= ratio_e - RATIO_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      wt  <= '0;
      lvl <= CFG_RST.sh;
    end else if (hold) begin
      cnt <= '0;
      wt  <= off_wrap(cfg.off, ratio_e);
      lvl <= cfg.sh;
    end else if (wt != '0) begin
      wt  <= wt - OFF_W'(1);
      lvl <= cfg.sh;
    end else begin
      lvl <= (cnt < half) ? cfg.sh : ~cfg.sh;
      cnt <= wrap ? '0 : cnt + RATIO_W'(1);
    end
  end

  // R3: a frozen channel shows its start level
  p_hold_static_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (lvl == $past(cfg.sh)));

  // R4: offset wait counts down one per cycle once released
  p_offset_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && wt != '0) |=> (wt == $past(wt) - OFF_W'(1)));

  // R7: the phase counter never leaves the period once running
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wrap) |=> (cnt == '0));

  // R5: an opted-out channel keeps counting through a request
  p_optout_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hold && cfg.ign && wt == '0 && !wrap) |=> (cnt == $past(cnt) + RATIO_W'(1)));

endmodule

// File: rtl/clkdiv_sync_bank.sv
module clkdiv_sync_bank
  import cdiv_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int FAN      = 3,
  parameter int PIPE_LAT = 12,
  parameter int ADDR_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CFG_W-1:0]   wr_data,
  input  logic               upd,
  output logic [NCH*FAN-1:0] clk_out
);

  ch_cfg_t [NCH-1:0] act;
  logic              soft_act;
  logic              hold;
  logic [NCH-1:0]    lvl;

  cdiv_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .upd      (upd),
    .act      (act),
    .soft_act (soft_act)
  );

  cdiv_sync_pipe #(.PIPE_LAT(PIPE_LAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_n   (sync_n),
    .soft_req (soft_act),
    .hold     (hold)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cdiv_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_hold (hold),
      .cfg       (act[c]),
      .lvl       (lvl[c])
    );
    for (genvar f = 0; f < FAN; f++) begin : g_fan
      assign clk_out[c*FAN+f] = lvl[c];
    end
    // R8: all outputs of one group agree
    p_group_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_out[c*FAN +: FAN] == {FAN{clk_out[c*FAN]}}));
  end

endmodule

// File: tb/clkdiv_sync_bank_tb.sv
module clkdiv_sync_bank_tb;

  localparam int NCH  = 4;
  localparam int FAN  = 3;
  localparam int L    = 12;
  localparam int MAXC = 4000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sync_n = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [12:0]       wr_data = '0;
  logic              upd = 1'b0;
  logic [NCH*FAN-1:0] clk_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  clkdiv_sync_bank u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .upd(upd), .clk_out(clk_out)
  );

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [12:0] m_stg [NCH];
  int  m_ratio [NCH];
  int  m_off   [NCH];
  bit  m_sh    [NCH];
  bit  m_ign   [NCH];
  bit  m_stg_soft = 0;
  bit  m_soft = 0;
  int  m_ph  [NCH];
  int  m_wt  [NCH];
  bit  pin_hist  [MAXC+1];
  bit  soft_hist [MAXC+1];
  int  n = 0;
  logic [NCH*FAN-1:0] expq [$];

  function automatic int lim(input int v);
    return (v < 2) ? 2 : ((v > 32) ? 32 : v);
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_stg[c] = {1'b0, 1'b1, 5'd0, 6'd2};
      m_ratio[c] = 2; m_off[c] = 0; m_sh[c] = 1; m_ign[c] = 0;
      m_ph[c] = 0; m_wt[c] = 0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && n < MAXC) begin
      logic [NCH*FAN-1:0] e;
      bit frz;
      n = n + 1;
      pin_hist[n] = sync_n;
      frz = ((n - L - 2 >= 1) ? !pin_hist[n-L-2] : 1'b0) |
            ((n - 1 - L >= 1) ? soft_hist[n-1-L] : 1'b0);
      for (int c = 0; c < NCH; c++) begin
        int r;
        bit v;
        r = lim(m_ratio[c]);
        if (frz && !m_ign[c]) begin
          v = m_sh[c]; m_ph[c] = 0; m_wt[c] = m_off[c] % r;
        end else if (m_wt[c] > 0) begin
          v = m_sh[c]; m_wt[c] = m_wt[c] - 1;
        end else begin
          v = (m_ph[c] < (r + 1) / 2) ? m_sh[c] : !m_sh[c];
          m_ph[c] = (m_ph[c] + 1 >= r) ? 0 : m_ph[c] + 1;
        end
        for (int f = 0; f < FAN; f++) e[c*FAN+f] = v;
      end
      expq.push_back(e);
      if (wr_en) begin
        if (wr_addr < 3'(NCH)) m_stg[wr_addr] = wr_data;
        else if (wr_addr == 3'(NCH)) m_stg_soft = wr_data[0];
      end
      if (upd) begin
        for (int c = 0; c < NCH; c++) begin
          m_ratio[c] = int'(m_stg[c][5:0]);
          m_off[c]   = int'(m_stg[c][10:6]);
          m_sh[c]    = m_stg[c][11];
          m_ign[c]   = m_stg[c][12];
        end
        m_soft = m_stg_soft;
      end
      soft_hist[n] = m_soft;
    end
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n && expq.size() > 0) begin
      logic [NCH*FAN-1:0] x;
      x = expq.pop_front();
      checks++;
      if (clk_out !== x) begin
        errors++;
        $display("FAIL %s: clk_out=%h expected %h (cycle %0d)", cur_req, clk_out, x, n);
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [12:0] cfgw(input int ratio, input int off, input bit sh, input bit ign);
    return {ign, sh, 5'(off), 6'(ratio)};
  endfunction

  task automatic wr(input int a, input logic [12:0] d, input bit with_upd);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; upd = with_upd;
    @(negedge clk);
    wr_en = 1'b0; upd = 1'b0;
  endtask

  task automatic do_upd();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    report();
    $finish;
  end

  initial begin
    // R1: reset values
    cyc(3);
    checks++;
    if (clk_out !== '1) begin
      errors++;
      $display("FAIL R1: clk_out=%h expected %h during reset", clk_out, {NCH*FAN{1'b1}});
    end
    rst_n = 1'b1;
    cur_req = "R1";
    cyc(10);

    // R2: staged writes do not act until update
    cur_req = "R2";
    wr(0, cfgw(4, 0, 1, 0), 0);
    wr(1, cfgw(5, 2, 0, 0), 0);
    wr(2, cfgw(7, 9, 1, 0), 0);
    wr(5, cfgw(9, 1, 0, 1), 0);
    cyc(10);
    // R2: write in the same cycle as the update is included
    wr(3, cfgw(3, 0, 0, 1), 1);
    cyc(20);

    // R3 / R4 / R5 / R8: pin request
    cur_req = "R3";
    @(negedge clk); sync_n = 1'b0;
    cyc(30);
    cur_req = "R4";
    sync_n = 1'b1;
    cyc(60);

    // R6: software request through staged and active copies
    cur_req = "R6";
    wr(4, 13'd1, 0);
    cyc(20);
    do_upd();
    cyc(30);
    wr(4, 13'd0, 1);
    cyc(40);

    // R6: overlapping pin and software requests
    wr(4, 13'd1, 1);
    cyc(5);
    @(negedge clk); sync_n = 1'b0;
    cyc(10);
    wr(4, 13'd0, 1);
    cyc(10);
    sync_n = 1'b1;
    cyc(50);

    // R7: ratio limits and wrapped offsets
    cur_req = "R7";
    wr(0, cfgw(1, 0, 1, 0), 0);
    wr(1, cfgw(50, 31, 0, 0), 0);
    wr(2, cfgw(33, 3, 1, 0), 0);
    wr(3, cfgw(6, 31, 0, 0), 1);
    @(negedge clk); sync_n = 1'b0;
    cyc(20);
    sync_n = 1'b1;
    cyc(140);

    // R5: opt-out flag on a running channel while others freeze
    cur_req = "R5";
    wr(2, cfgw(5, 0, 1, 1), 1);
    @(negedge clk); sync_n = 1'b0;
    cyc(25);
    sync_n = 1'b1;
    cyc(40);

    cyc(2);
    report();
    $finish;
  end

endmodule